// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps an offset inside a fixed local outbound region onto a 64-bit PCIe bus address. The region is cut into a parameterised number of equally sized windows. Each window holds its own 64-bit target base and its own enable flag. A shared size index selects the window size as 2^k megabytes. A global enable bit switches translation on and off for every window at once. Software programs all of this through a word-wide write port with a combinational read-back.

Lookups use a valid/ready stream. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The answer appears on the response stream one cycle later, as either a translated address or a miss flag. The response register is a single stage. `req_ready` is high when that stage is empty, or when its current response is being taken in the same cycle. While `resp_valid` is high and `resp_ready` is low, the response stays unchanged and no new request is accepted. Issuing the bus transaction and decoding the region itself are done outside this block.

Top module: `obx_xlate`

## Requirements
- R1: After reset, `resp_valid` is low, translation is off, and every register reads back as zero.
- R2: The size register is at byte address 0x030. Its bits [2:0] hold the index k, the window size is 2^(20+k) bytes, and its other bits read back as zero.
- R3: For window n, the low word is at 0x200+8n and the high word at 0x204+8n. Bit 0 of the low word enables the window, and bits [31:1] of the low word are bits [31:1] of the target base. The high word is bits [63:32] of the base, and bit 0 of the base is zero. Both words read back exactly as they were written.
- R4: Bit 1 of the control register at 0x004 is the global translation enable. The other bits of that register read back as zero.
- R5: For an accepted offset, the window index is offset >> (20+k). On a hit, `resp_addr` = base + (offset mod 2^(20+k)), with the carry propagating into the high word, and `resp_miss` = 0.
- R6: While the global enable is clear, every lookup returns `resp_miss` = 1 and `resp_addr` = 0.
- R7: A lookup that falls in a window whose enable bit is clear returns a miss with `resp_addr` = 0.
- R8: A lookup whose window index is NUM_WIN or more returns a miss with `resp_addr` = 0.
- R9: A request accepted on one rising edge gives `resp_valid` = 1 immediately after that edge, which is a latency of one cycle.
- R10: `req_ready` = !resp_valid || resp_ready. While the response is stalled, `resp_addr` and `resp_miss` hold their values.
- R11: A register write on the same edge that accepts a request does not affect that request. The next request accepted afterwards uses the new value.
- R12: Writes to addresses with no register behind them, including windows NUM_WIN and above, change nothing, and those addresses read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | RA_W | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_offset | input | OFF_W | Offset inside the outbound region |
| resp_valid | output | 1 | Lookup result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_miss | output | 1 | Lookup missed |
| resp_addr | output | 64 | Translated bus address (zero on a miss) |

## Verification
The bench builds the block with NUM_WIN = 8 and OFF_W = 32. With this setting, the out-of-range miss is reached at only 8 MB when k = 0, and the register decode for windows past the last one can be probed at 0x240. The 32-bit offset still allows the largest index, k = 7. The bench also runs a base whose low word carries into the high word when the remainder is added, and it stalls the response stream with a second request waiting behind it.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int WORD_W   = 32;
  localparam int TADDR_W  = 64;
  localparam int MB_LOG2  = 20;
  localparam int CTRL_ADR = 'h004;
  localparam int SIZE_ADR = 'h030;
  localparam int WIN_ADR  = 'h200;
  localparam int XEN_BIT  = 1;

  typedef struct packed {
    logic [WORD_W-1:0] hi;
    logic [WORD_W-1:0] lo;
  } win_t;
endpackage

// File: rtl/obx_regs.sv
module obx_regs
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int RA_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [RA_W-1:0]   addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              xlate_on,
  output logic [2:0]        size_idx,
  output win_t              wins [NUM_WIN]
);
  localparam int WIN_END = WIN_ADR + 8 * NUM_WIN;
  localparam int IW      = $clog2(NUM_WIN);

  logic           in_win;
  logic [IW-1:0]  wsel;
  logic           whi;
  logic [RA_W-1:0] rel;

  assign in_win = (int'(addr) >= WIN_ADR) && (int'(addr) < WIN_END);
  assign rel    = addr - RA_W'(WIN_ADR);
  assign wsel   = rel[IW+2:3];
  assign whi    = rel[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlate_on <= 1'b0;
      size_idx <= '0;
    end else if (wr) begin
      if (int'(addr) == CTRL_ADR) xlate_on <= wdata[XEN_BIT];
      if (int'(addr) == SIZE_ADR) size_idx <= wdata[2:0];
    end
  end

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wins[n] <= '0;
      end else if (wr && in_win && (int'(wsel) == n)) begin
        if (whi) wins[n].hi <= wdata;
        else     wins[n].lo <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) == CTRL_ADR)      rdata[XEN_BIT] = xlate_on;
    else if (int'(addr) == SIZE_ADR) rdata[2:0] = size_idx;
    else if (in_win)                 rdata = whi ? wins[wsel].hi : wins[wsel].lo;
  end
endmodule

// File: rtl/obx_lookup.sv
module obx_lookup
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int OFF_W   = 32
) (
  input  logic [OFF_W-1:0]   offset,
  input  logic [2:0]         size_idx,
  input  logic               xlate_on,
  input  win_t               wins [NUM_WIN],
  output logic               hit,
  output logic [TADDR_W-1:0] taddr
);
  localparam int IW = $clog2(NUM_WIN);

  logic [6:0]         shift;
  logic [OFF_W-1:0]   idx_full;
  logic [OFF_W-1:0]   rem;
  logic               in_range;
  win_t               sel;
  logic [TADDR_W-1:0] base;

  always_comb begin
    shift    = 7'(MB_LOG2) + 7'(size_idx);
    idx_full = offset >> shift;
    rem      = offset & ~({OFF_W{1'b1}} << shift);
    in_range = idx_full < OFF_W'(NUM_WIN);
    sel      = wins[idx_full[IW-1:0]];
    base     = {sel.hi, sel.lo[WORD_W-1:1], 1'b0};
    hit      = xlate_on && in_range && sel.lo[0];
    taddr    = base + TADDR_W'(rem);
  end
endmodule

// File: rtl/obx_xlate.sv
module obx_xlate
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int OFF_W   = 32,
  parameter int RA_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [RA_W-1:0]    cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [OFF_W-1:0]   req_offset,
  output logic               resp_valid,
  input  logic               resp_ready,
  output logic               resp_miss,
  output logic [63:0]        resp_addr
);
  logic               xlate_on;
  logic [2:0]         size_idx;
  win_t               wins [NUM_WIN];
  logic               hit;
  logic [TADDR_W-1:0] taddr;
  logic               accept;

  obx_regs #(.NUM_WIN(NUM_WIN), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .xlate_on(xlate_on),
    .size_idx(size_idx), .wins(wins)
  );

  obx_lookup #(.NUM_WIN(NUM_WIN), .OFF_W(OFF_W)) u_look (
    .offset(req_offset), .size_idx(size_idx), .xlate_on(xlate_on),
    .wins(wins), .hit(hit), .taddr(taddr)
  );

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_miss  <= 1'b0;
      resp_addr  <= '0;
    end else begin
      if (accept) begin
        resp_valid <= 1'b1;
        resp_miss  <= !hit;
        resp_addr  <= hit ? taddr : '0;
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> resp_valid); // R9
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_addr) && $stable(resp_miss)); // R10
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !req_ready); // R10
  AST_OFF_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !xlate_on |=> resp_miss && resp_addr == 64'd0); // R6
endmodule

// File: tb/sim_obx_xlate.sv
module sim_obx_xlate;
  localparam int PERIOD  = 10;
  localparam int NUM_WIN = 8;
  localparam int OFF_W   = 32;
  localparam int RA_W    = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [RA_W-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [OFF_W-1:0] req_offset = '0;
  logic resp_valid;
  logic resp_ready = 1'b1;
  logic resp_miss;
  logic [63:0] resp_addr;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  obx_xlate #(.NUM_WIN(NUM_WIN), .OFF_W(OFF_W), .RA_W(RA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_offset(req_offset), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_miss(resp_miss), .resp_addr(resp_addr)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = RA_W'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = RA_W'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic look(logic [OFF_W-1:0] o, string req, logic miss, logic [63:0] ea);
    @(negedge clk);
    req_valid = 1'b1; req_offset = o;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 64'(resp_valid), 64'd1);
    check({req, " miss"}, 64'(resp_miss), 64'(miss));
    check({req, " addr"}, resp_addr, ea);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 resp_valid", 64'(resp_valid), 64'd0);
    rd('h004, d); check("R1 ctrl", 64'(d), 64'd0);
    rd('h030, d); check("R1 size", 64'(d), 64'd0);
    rd('h218, d); check("R1 win3 lo", 64'(d), 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr('h030, 32'hFFFF_FFFA); rd('h030, d); check("R2 size readback", 64'(d), 64'd2);
    wr('h030, 32'h0);
    wr('h004, 32'hFFFF_FFFF); rd('h004, d); check("R4 ctrl readback", 64'(d), 64'd2);
    wr('h218, 32'h8000_0001); wr('h21C, 32'h0000_0001);
    rd('h218, d); check("R3 win3 lo", 64'(d), 64'h8000_0001);
    rd('h21C, d); check("R3 win3 hi", 64'(d), 64'h1);
    wr('h208, 32'h4000_0000); wr('h20C, 32'h0);
    wr('h228, 32'hFFF8_0001); wr('h22C, 32'h2);
    wr('h240, 32'hDEAD_BEEF); rd('h240, d); check("R12 win8 ignored", 64'(d), 64'd0);
    wr('h100, 32'h1234_5678); rd('h100, d); check("R12 hole ignored", 64'(d), 64'd0);
    rd('h218, d); check("R12 win3 untouched", 64'(d), 64'h8000_0001);
  endtask

  task automatic t_xlate();
    look(32'h0030_1234, "R5 k0 win3", 1'b0, 64'h1_8000_1234);
    look(32'h005F_FFFF, "R5 carry win5", 1'b0, 64'h3_0007_FFFF);
    look(32'h0010_0000, "R7 win1 disabled", 1'b1, 64'd0);
    look(32'h0080_0000, "R8 index 8", 1'b1, 64'd0);
    wr('h030, 32'h2);
    look(32'h00C0_0010, "R5 k2 win3", 1'b0, 64'h1_8000_0010);
    wr('h030, 32'h7);
    look(32'h1800_0044, "R5 k7 win3", 1'b0, 64'h1_8000_0044);
    look(32'hFFFF_FFFF, "R8 k7 index 31", 1'b1, 64'd0);
    wr('h030, 32'h0);
  endtask

  task automatic t_off();
    wr('h004, 32'h0);
    look(32'h0030_1234, "R6 global off", 1'b1, 64'd0);
    wr('h004, 32'h2);
  endtask

  task automatic t_same_edge();
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = RA_W'('h030); cfg_wdata = 32'h2;
    req_valid = 1'b1; req_offset = 32'h0030_0008;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    check("R11 old size miss", 64'(resp_miss), 64'd0);
    check("R11 old size addr", resp_addr, 64'h1_8000_0008);
    look(32'h0030_0008, "R11 new size", 1'b1, 64'd0);
    wr('h030, 32'h0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    resp_ready = 1'b0; req_valid = 1'b1; req_offset = 32'h0030_0001;
    @(negedge clk);
    check("R9 valid after one edge", 64'(resp_valid), 64'd1);
    check("R10 ready low when full", 64'(req_ready), 64'd0);
    req_offset = 32'h0050_0000;
    @(negedge clk); @(negedge clk);
    check("R10 held addr", resp_addr, 64'h1_8000_0001);
    check("R10 held valid", 64'(resp_valid), 64'd1);
    resp_ready = 1'b1;
    #1 check("R10 ready follows resp_ready", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 next resp", resp_addr, 64'h2_FFF8_0000);
    @(negedge clk);
    check("R10 drained", 64'(resp_valid), 64'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 3);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_xlate();
    t_off();
    t_same_edge();
    t_stall();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule